// File: doc/BRIEF.md
# Burst Address Counter with Register Readback

This block is the address-generation stage of one port of a synchronous multi-port memory. It holds a burst counter and a mask register. Both registers are written from the port's address bus. The counter can be loaded, or it can step by one. When it steps, only the bit positions selected by the mask change, so a burst can circle inside a window of the address space. The upper bits outside the window stay fixed.

Two active-low readback requests place either register back onto the address bus. In that cycle the bus turns into an output. The value appears one clock after the request. Readback works whatever the state of the chip selects. When the chip is selected while a readback runs, the block also reports that the data I/O drivers must stay off. A single-cycle active-low flag marks each increment that brings the windowed bits of the counter back to zero.

Top module: `burst_addr_ctr`

## Requirements
- R1: After reset the counter is zero, the mask is all ones, `cnt_wrap_n` is 1, `addr_oe` is 0 and `dq_off` is 0.
- R2: A clock edge with `cnt_ld_n` low copies `addr_i` into the counter. Load takes priority over increment when both are low.
- R3: A clock edge with `cnt_inc_n` low and `cnt_ld_n` high sets the counter to ((cnt+1) AND mask) OR (cnt AND NOT mask). Bits where the mask is 0 do not change.
- R4: A clock edge with `msk_ld_n` low and both `cnt_ld_n` and `cnt_inc_n` high copies `addr_i` into the mask. If either counter control is low, the mask load is ignored.
- R5: If `cnt_rb_n` is low at an edge with both counter controls high, then after that edge `addr_oe` is 1 for one cycle and `addr_o` holds the counter value from before the edge. If a counter control is low, the request is ignored.
- R6: If `msk_rb_n` is low at an edge where `cnt_ld_n`, `cnt_inc_n`, `msk_ld_n` and `cnt_rb_n` are all high, then after that edge `addr_oe` is 1 and `addr_o` holds the mask. Otherwise the request is ignored.
- R7: When both readback requests are valid at the same edge, `addr_o` returns the counter.
- R8: Readback is honoured whatever the values of `cs_n` and `cs_hi`.
- R9: `dq_off` is 1 exactly in the output cycle of a readback whose request edge saw the chip selected (`cs_n` = 0 and `cs_hi` = 1). Otherwise it is 0.
- R10: `addr_oe` is 1 only in the cycle after an honoured readback request.
- R11: `cnt_wrap_n` is 0 for the one cycle after an increment edge at which the mask is nonzero and the mask-selected bits of the new counter value are all zero. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Address bus, input side |
| addr_o | output | ADDR_W | Address bus, readback value |
| addr_oe | output | 1 | Address bus output enable |
| cnt_ld_n | input | 1 | Counter load, active low |
| cnt_inc_n | input | 1 | Counter increment, active low |
| msk_ld_n | input | 1 | Mask load, active low |
| cnt_rb_n | input | 1 | Counter readback request, active low |
| msk_rb_n | input | 1 | Mask readback request, active low |
| cs_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| dq_off | output | 1 | Forces the data I/O drivers off |
| cnt_wrap_n | output | 1 | Counter wrap flag, active low, one cycle |

## Verification
The hardest case to reach is a wrap inside a narrow mask window, where the fixed upper bits are nonzero. Reaching it needs a mask load, then a counter load just below the window boundary, then several increments in a row. None of this is visible until a counter readback follows. The directed sequence builds exactly that chain. A long run of weighted random controls then mixes loads, increments, colliding requests and chip-select states. A behavioural model is compared against the outputs on every clock.

// File: rtl/bac_pkg.sv
package bac_pkg;

   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_LOAD = 2'd1,
      CNT_STEP = 2'd2
   } cnt_op_e;

   typedef enum logic [1:0] {
      RB_NONE = 2'd0,
      RB_CNT  = 2'd1,
      RB_MSK  = 2'd2
   } rb_sel_e;

endpackage

// File: rtl/bac_decode.sv
module bac_decode
   import bac_pkg::*;
(
   input  logic    cnt_ld_n,
   input  logic    cnt_inc_n,
   input  logic    msk_ld_n,
   input  logic    cnt_rb_n,
   input  logic    msk_rb_n,
   input  logic    cs_n,
   input  logic    cs_hi,
   output cnt_op_e cnt_op,
   output logic    msk_we,
   output rb_sel_e rb_sel,
   output logic    chip_sel
);

   logic ctr_quiet;

   // counter controls both inactive: mask load and readback may proceed
   assign ctr_quiet = cnt_ld_n & cnt_inc_n;

   always_comb begin
      if (!cnt_ld_n)       cnt_op = CNT_LOAD;
      else if (!cnt_inc_n) cnt_op = CNT_STEP;
      else                 cnt_op = CNT_HOLD;
   end

   assign msk_we = ctr_quiet & ~msk_ld_n;

   // counter readback outranks mask readback
   always_comb begin
      if (ctr_quiet && !cnt_rb_n)                   rb_sel = RB_CNT;
      else if (ctr_quiet && msk_ld_n && !msk_rb_n)  rb_sel = RB_MSK;
      else                                          rb_sel = RB_NONE;
   end

   assign chip_sel = ~cs_n & cs_hi;

endmodule

// File: rtl/bac_core.sv
module bac_core
   import bac_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter bit MASK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cnt_op_e           cnt_op,
   input  logic              msk_we,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] cnt_q,
   output logic [ADDR_W-1:0] msk_q,
   output logic              wrap_n_q
);

   localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] cnt_step;
   logic              step_wraps;

   assign cnt_step   = ((cnt_q + ONE) & msk_q) | (cnt_q & ~msk_q);
   assign step_wraps = (msk_q != '0) && ((cnt_step & msk_q) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         wrap_n_q <= 1'b1;
      end else begin
         wrap_n_q <= 1'b1;
         unique case (cnt_op)
            CNT_LOAD: cnt_q <= addr_i;
            CNT_STEP: begin
               cnt_q    <= cnt_step;
               wrap_n_q <= ~step_wraps;
            end
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   generate
      if (MASK_EN) begin : g_mask_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      msk_q <= ALL_ONES;
            else if (msk_we) msk_q <= addr_i;
         end
      end else begin : g_mask_fixed
         assign msk_q = ALL_ONES;
      end
   endgenerate

endmodule

// File: rtl/bac_readback.sv
module bac_readback
   import bac_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rb_sel_e           rb_sel,
   input  logic              chip_sel,
   input  logic [ADDR_W-1:0] cnt_q,
   input  logic [ADDR_W-1:0] msk_q,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_oe,
   output logic              dq_off
);

   logic rb_any;
   assign rb_any = (rb_sel != RB_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o  <= '0;
         addr_oe <= 1'b0;
         dq_off  <= 1'b0;
      end else begin
         addr_oe <= rb_any;
         dq_off  <= rb_any & chip_sel;
         if (rb_sel == RB_CNT)      addr_o <= cnt_q;
         else if (rb_sel == RB_MSK) addr_o <= msk_q;
      end
   end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
   import bac_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter bit MASK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_oe,
   input  logic              cnt_ld_n,
   input  logic              cnt_inc_n,
   input  logic              msk_ld_n,
   input  logic              cnt_rb_n,
   input  logic              msk_rb_n,
   input  logic              cs_n,
   input  logic              cs_hi,
   output logic              dq_off,
   output logic              cnt_wrap_n
);

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_width
         $error("burst_addr_ctr: ADDR_W must lie in 2..32");
      end
   endgenerate

   cnt_op_e           cnt_op;
   rb_sel_e           rb_sel;
   logic              msk_we;
   logic              chip_sel;
   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] msk_q;

   bac_decode u_dec (
      .cnt_ld_n (cnt_ld_n),
      .cnt_inc_n(cnt_inc_n),
      .msk_ld_n (msk_ld_n),
      .cnt_rb_n (cnt_rb_n),
      .msk_rb_n (msk_rb_n),
      .cs_n     (cs_n),
      .cs_hi    (cs_hi),
      .cnt_op   (cnt_op),
      .msk_we   (msk_we),
      .rb_sel   (rb_sel),
      .chip_sel (chip_sel)
   );

   bac_core #(.ADDR_W(ADDR_W), .MASK_EN(MASK_EN)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_op  (cnt_op),
      .msk_we  (msk_we),
      .addr_i  (addr_i),
      .cnt_q   (cnt_q),
      .msk_q   (msk_q),
      .wrap_n_q(cnt_wrap_n)
   );

   bac_readback #(.ADDR_W(ADDR_W)) u_rb (
      .clk     (clk),
      .rst_n   (rst_n),
      .rb_sel  (rb_sel),
      .chip_sel(chip_sel),
      .cnt_q   (cnt_q),
      .msk_q   (msk_q),
      .addr_o  (addr_o),
      .addr_oe (addr_oe),
      .dq_off  (dq_off)
   );

endmodule

// File: rtl/bac_checker.sv
module bac_checker (
   input logic clk,
   input logic rst_n,
   input logic cnt_ld_n,
   input logic cnt_inc_n,
   input logic msk_ld_n,
   input logic cnt_rb_n,
   input logic msk_rb_n,
   input logic cs_n,
   input logic cs_hi,
   input logic addr_oe,
   input logic dq_off,
   input logic cnt_wrap_n
);

   a_r5_cnt_rb_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_rb_n && cnt_ld_n && cnt_inc_n) |=> addr_oe);

   a_r6_msk_rb_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (!msk_rb_n && cnt_rb_n && cnt_ld_n && cnt_inc_n && msk_ld_n) |=> addr_oe);

   a_r10_oe_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      addr_oe |-> $past(!cnt_rb_n || !msk_rb_n));

   a_r9_dq_off_inside_rb: assert property (@(posedge clk) disable iff (!rst_n)
      dq_off |-> addr_oe);

   a_r9_dq_off_on_select: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_rb_n && cnt_ld_n && cnt_inc_n && !cs_n && cs_hi) |=> dq_off);

   a_r11_wrap_after_step: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wrap_n |-> $past(!cnt_inc_n && cnt_ld_n));

endmodule

bind burst_addr_ctr bac_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_ld_n  (cnt_ld_n),
   .cnt_inc_n (cnt_inc_n),
   .msk_ld_n  (msk_ld_n),
   .cnt_rb_n  (cnt_rb_n),
   .msk_rb_n  (msk_rb_n),
   .cs_n      (cs_n),
   .cs_hi     (cs_hi),
   .addr_oe   (addr_oe),
   .dq_off    (dq_off),
   .cnt_wrap_n(cnt_wrap_n)
);

// File: tb/burst_addr_ctr_tb.sv
module burst_addr_ctr_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] addr_i = '0;
   logic [W-1:0] addr_o;
   logic         addr_oe, dq_off, cnt_wrap_n;
   logic         cnt_ld_n = 1, cnt_inc_n = 1, msk_ld_n = 1, cnt_rb_n = 1, msk_rb_n = 1;
   logic         cs_n = 1, cs_hi = 0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   string tag = "R5";

   // behavioural reference state
   int m_cnt, m_msk, e_ao;
   bit e_oe, e_off, e_wrap_n;

   always #4 clk = ~clk;

   burst_addr_ctr #(.ADDR_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .addr_o(addr_o), .addr_oe(addr_oe),
      .cnt_ld_n(cnt_ld_n), .cnt_inc_n(cnt_inc_n), .msk_ld_n(msk_ld_n),
      .cnt_rb_n(cnt_rb_n), .msk_rb_n(msk_rb_n), .cs_n(cs_n), .cs_hi(cs_hi),
      .dq_off(dq_off), .cnt_wrap_n(cnt_wrap_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // model advance at the rising edge, compare at the following falling edge
   task automatic tick();
      bit rb_c, rb_m;
      int nxt;
      @(posedge clk);
      rb_c = !cnt_rb_n && cnt_ld_n && cnt_inc_n;
      rb_m = !msk_rb_n && cnt_rb_n && cnt_ld_n && cnt_inc_n && msk_ld_n;
      e_oe  = rb_c || rb_m;
      e_off = e_oe && !cs_n && cs_hi;
      if (rb_c) e_ao = m_cnt;
      else if (rb_m) e_ao = m_msk;
      e_wrap_n = 1;
      if (!cnt_ld_n) m_cnt = int'(addr_i);
      else if (!cnt_inc_n) begin
         nxt = 0;
         for (int b = 0; b < W; b++)
            if (m_msk[b]) nxt[b] = (m_cnt + 1) >> b & 1;
            else          nxt[b] = m_cnt[b];
         if (m_msk != 0 && (nxt & m_msk) == 0) e_wrap_n = 0;
         m_cnt = nxt;
      end else if (!msk_ld_n) m_msk = int'(addr_i);
      @(negedge clk);
      chk(addr_oe == e_oe, "R10", int'(addr_oe), int'(e_oe));
      if (e_oe) chk(int'(addr_o) == e_ao, tag, int'(addr_o), e_ao);
      chk(dq_off == e_off, "R9", int'(dq_off), int'(e_off));
      chk(cnt_wrap_n == e_wrap_n, "R11", int'(cnt_wrap_n), int'(e_wrap_n));
   endtask

   task automatic drive(input bit ld, input bit inc, input bit ml, input bit cr,
                        input bit mr, input bit sel, input int a);
      cnt_ld_n = ~ld; cnt_inc_n = ~inc; msk_ld_n = ~ml;
      cnt_rb_n = ~cr; msk_rb_n = ~mr;
      cs_n = ~sel; cs_hi = sel;
      addr_i = a[W-1:0];
      tick();
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      m_cnt = 0; m_msk = 255; e_ao = 0;
      repeat (3) @(negedge clk);
      // R1: reset values at the ports
      chk(addr_oe == 0, "R1", int'(addr_oe), 0);
      chk(dq_off == 0, "R1", int'(dq_off), 0);
      chk(cnt_wrap_n == 1, "R1", int'(cnt_wrap_n), 1);
      rst_n = 1;
      tag = "R1"; drive(0, 0, 0, 1, 0, 0, 0); idle();
      drive(0, 0, 0, 0, 1, 0, 0); idle();
      // R2: load, and load over increment
      tag = "R2"; drive(1, 0, 0, 0, 0, 0, 'h5A); drive(0, 0, 0, 1, 0, 0, 0); idle();
      drive(1, 1, 0, 0, 0, 0, 'h33); drive(0, 0, 0, 1, 0, 0, 0);
      // R3: plain increments
      tag = "R3"; repeat (3) drive(0, 1, 0, 0, 0, 0, 0); drive(0, 0, 0, 1, 0, 0, 0);
      // R4: mask load and readback
      tag = "R4"; drive(0, 0, 1, 0, 0, 0, 'h0F); drive(0, 0, 0, 0, 1, 0, 0);
      // R11 and R3: wrap inside a 4-bit window with upper bits fixed
      drive(1, 0, 0, 0, 0, 0, 'hAE);
      tag = "R3"; repeat (3) drive(0, 1, 0, 0, 0, 0, 0); drive(0, 0, 0, 1, 0, 0, 0);
      // R4: mask load ignored while a counter control is low
      tag = "R4"; drive(1, 0, 1, 0, 0, 0, 'h03); drive(0, 0, 0, 0, 1, 0, 0);
      drive(0, 1, 1, 0, 0, 0, 'h01); drive(0, 0, 0, 0, 1, 0, 0);
      // R7: both readbacks requested
      tag = "R7"; drive(0, 0, 0, 1, 1, 0, 0); idle();
      // R8 and R9: readback with chip selected and not selected
      tag = "R8"; drive(0, 0, 0, 1, 0, 1, 0); drive(0, 0, 0, 0, 1, 1, 0);
      drive(0, 0, 0, 1, 0, 0, 0); idle();
      // R5: readback ignored under increment; R6: ignored under mask load
      tag = "R5"; drive(0, 1, 0, 1, 0, 0, 0); idle();
      tag = "R6"; drive(0, 0, 1, 0, 1, 0, 'h3F); drive(0, 0, 0, 0, 1, 0, 0); idle();
      // R10: mixed traffic under random controls
      tag = "R10";
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom;
         drive((r & 15) == 0, (r >> 4 & 3) == 0, (r >> 6 & 7) == 0,
               (r >> 9 & 3) == 0, (r >> 11 & 3) == 0, r[13], $urandom);
      end
      idle();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule